// File: doc/BRIEF.md
# Packet-mode I2C command decoder

This block is the front end of an I2C master that is fed with packets instead of register writes. Software pushes 32-bit words into a transmit FIFO; the decoder pops them through a valid/ready handshake, reads a three-word preamble per packet, and turns it into one command for a byte-level bus engine. The command names the target address, the direction, the addressing width, the number of bytes and what the engine does on the bus once the last byte is done: release it with a STOP, keep it with a repeated START, or simply continue.

For a write the payload words that follow the preamble are cut into bytes, lowest byte first, and handed to the engine one at a time. For a read no payload words follow. The engine reports every finished byte, a missing acknowledge and a lost arbitration. The decoder counts finished bytes, raises a one-cycle packet-complete flag on the last one and returns to waiting for the next packet. Failed packets are cleaned out of the word stream so the next packet starts on a header word.

Top module: `pkt_i2c_decoder`

## Requirements
- R1: A first header word with bit 4 clear is a malformed packet: it raises irqPulse bit 1 for one cycle, issues no command and consumes exactly the two following preamble words plus, when bit 19 of the third word is clear, ceil(len/4) payload words.
- R2: The low LEN_W bits of the second word hold len-1 and appear on cmdLenM1; after len byte-done reports the decoder raises irqPulse bit 7 for exactly one cycle and returns to idle.
- R3: From the third word, bits 9:0 give the address, bit 19 the direction (1 = read, cmdRead) and bit 18 ten-bit mode (cmdTenBit); in seven-bit mode cmdAddr bit 0 is replaced by the read bit, in ten-bit mode all ten bits pass unchanged; the command is held on cmdValid until cmdReady.
- R4: cmdEnd is 2 (continue) when third-word bit 15 is set, otherwise 1 (repeated START) when bit 16 is set, otherwise 0 (STOP).
- R5: Write payload words are issued on txByte little-endian (bits 7:0 first), exactly len bytes, the unused upper bytes of the last word dropped.
- R6: A read packet consumes no payload words: the word after its third word is treated as the next packet's first header word.
- R7: An engine NACK during a transfer raises irqPulse bit 3; when third-word bit 21 is clear the packet is aborted with no complete flag, buffered bytes are discarded and the remaining payload words are consumed; when bit 21 is set the transfer continues to completion.
- R8: A lost arbitration during a transfer raises irqPulse bit 2 and always aborts the packet like R7.
- R9: Engine reports while no transfer is running raise no flag and do not disturb the byte count of the next packet.
- R10: After reset inReady is 1 and cmdValid, txValid and irqPulse are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inWord | input | 32 | Word from the transmit FIFO |
| inValid | input | 1 | inWord is valid |
| inReady | output | 1 | Decoder takes inWord this cycle |
| cmdValid | output | 1 | Command is presented |
| cmdReady | input | 1 | Engine accepts the command |
| cmdAddr | output | 10 | Target address field |
| cmdRead | output | 1 | Transfer direction, 1 = read |
| cmdTenBit | output | 1 | Ten-bit addressing |
| cmdEnd | output | 2 | 0 STOP, 1 repeated START, 2 continue |
| cmdLenM1 | output | LEN_W | Byte count minus one |
| txByte | output | 8 | Write byte to the engine |
| txValid | output | 1 | txByte is valid |
| txReady | input | 1 | Engine takes txByte |
| engByteDone | input | 1 | Engine finished one byte |
| engNack | input | 1 | Engine saw no acknowledge |
| engArbLost | input | 1 | Engine lost arbitration |
| irqPulse | output | 8 | One-cycle flags: 7 complete, 3 NACK, 2 arbitration, 1 malformed |

## Verification
The bench aims at the places where the word stream can lose its framing: a malformed write whose payload must still be swallowed, a malformed read that must swallow nothing, and a NACK in the middle of an eight-byte write after the engine already holds a further byte. A decoder that miscounted any of these would read a payload word as the next header and emit a garbage command. It also drives a header with both continue and repeated START set, a one-byte write, a partial last word, a seven-bit address whose direction bit disagrees with the read flag, and a NACK that must be tolerated; wrong priority, wrong byte order or a stray extra byte show up directly on the command and byte outputs.

// File: rtl/pkt_dec_pkg.sv
package pkt_dec_pkg;

  // first header word
  localparam int PROTO_BIT    = 4;
  // I2C header word
  localparam int TENBIT_BIT   = 18;
  localparam int READ_BIT     = 19;
  localparam int CONT_BIT     = 15;
  localparam int RESTART_BIT  = 16;
  localparam int CONTNACK_BIT = 21;
  localparam int ADDR_W       = 10;

  // irq flag positions
  localparam int IRQ_DONE  = 7;
  localparam int IRQ_NACK  = 3;
  localparam int IRQ_ARB   = 2;
  localparam int IRQ_FMT   = 1;

  typedef enum logic [2:0] {
    ST_HDR0, ST_SIZE, ST_HDRI, ST_CMD, ST_XFER, ST_DRAIN
  } state_t;

  typedef enum logic [1:0] {
    END_STOP = 2'd0, END_RESTART = 2'd1, END_CONTINUE = 2'd2
  } end_t;

  typedef struct packed {
    logic capSize;
    logic capHdr;
    logic loadWord;
    logic dropWord;
    logic popByte;
    logic countDone;
    logic flush;
  } strobe_t;

endpackage

// File: rtl/pkt_dec_datapath.sv
module pkt_dec_datapath
  import pkt_dec_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [31:0]      inWord,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic             cmdRead,
  output logic             cmdTenBit,
  output logic [1:0]       cmdEnd,
  output logic [LEN_W-1:0] cmdLenM1,
  output logic             contNack,
  output logic [7:0]       txByte,
  output logic             bufEmpty,
  output logic             loadsLeft,
  output logic             lastDone
);

  localparam int TO_W = LEN_W + 1;

  logic [LEN_W-1:0] sizeReg, doneCnt;
  logic [TO_W-1:0]  toLoad;
  logic [31:0]      wordBuf, hdrReg;
  logic [2:0]       inBuf;
  logic [2:0]       chunk;

  always_comb chunk = (toLoad >= TO_W'(4)) ? 3'd4 : toLoad[2:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeReg <= '0;
      doneCnt <= '0;
      toLoad  <= '0;
      wordBuf <= '0;
      hdrReg  <= '0;
      inBuf   <= '0;
    end else begin
      if (stb.capSize) begin
        sizeReg <= inWord[LEN_W-1:0];
        toLoad  <= {1'b0, inWord[LEN_W-1:0]} + TO_W'(1);
        doneCnt <= '0;
        inBuf   <= '0;
      end
      if (stb.capHdr) begin
        hdrReg <= inWord;
        if (inWord[READ_BIT]) toLoad <= '0;
      end
      if (stb.loadWord) begin
        wordBuf <= inWord;
        inBuf   <= chunk;
        toLoad  <= toLoad - TO_W'(chunk);
      end
      if (stb.dropWord) toLoad <= toLoad - TO_W'(chunk);
      if (stb.popByte) begin
        wordBuf <= {8'h00, wordBuf[31:8]};
        inBuf   <= inBuf - 3'd1;
      end
      if (stb.countDone) doneCnt <= doneCnt + LEN_W'(1);
      if (stb.flush) inBuf <= '0;
    end
  end

  always_comb begin
    cmdRead   = hdrReg[READ_BIT];
    cmdTenBit = hdrReg[TENBIT_BIT];
    cmdAddr   = cmdTenBit ? hdrReg[ADDR_W-1:0] : {hdrReg[ADDR_W-1:1], hdrReg[READ_BIT]};
    if (hdrReg[CONT_BIT])         cmdEnd = END_CONTINUE;
    else if (hdrReg[RESTART_BIT]) cmdEnd = END_RESTART;
    else                          cmdEnd = END_STOP;
  end

  assign cmdLenM1  = sizeReg;
  assign contNack  = hdrReg[CONTNACK_BIT];
  assign txByte    = wordBuf[7:0];
  assign bufEmpty  = (inBuf == 3'd0);
  assign loadsLeft = (toLoad != '0);
  assign lastDone  = (doneCnt == sizeReg);

  // R5: a byte is only handed out while one is buffered
  assert_pop_has_byte_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.popByte |-> inBuf != 3'd0);
  // R5: a new word only enters an empty buffer with bytes still owed
  assert_load_when_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadWord |-> (inBuf == 3'd0) && (toLoad != '0));
  // R1, R7: discarding never runs past the packet
  assert_drop_has_words_R1: assert property (@(posedge clk) disable iff (!rstN)
    stb.dropWord |-> toLoad != '0);

endmodule

// File: rtl/pkt_dec_ctl.sv
module pkt_dec_ctl
  import pkt_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       protoOk,
  output logic       inReady,
  output logic       cmdValid,
  input  logic       cmdReady,
  output logic       txValid,
  input  logic       txReady,
  input  logic       engByteDone,
  input  logic       engNack,
  input  logic       engArbLost,
  input  logic       isRead,
  input  logic       contNack,
  input  logic       bufEmpty,
  input  logic       loadsLeft,
  input  logic       lastDone,
  output strobe_t    stb,
  output logic [7:0] irqPulse
);

  state_t state, stateNext;
  logic   badQ, badNext;
  logic   accept, abort, finish, inXfer;
  logic [7:0] irqNext;

  always_comb begin
    case (state)
      ST_HDR0, ST_SIZE, ST_HDRI: inReady = 1'b1;
      ST_XFER:  inReady = !isRead && bufEmpty && loadsLeft;
      ST_DRAIN: inReady = loadsLeft;
      default:  inReady = 1'b0;
    endcase
  end

  assign inXfer   = (state == ST_XFER);
  assign accept   = inValid && inReady;
  assign txValid  = inXfer && !isRead && !bufEmpty;
  assign cmdValid = (state == ST_CMD);
  assign abort    = inXfer && (engArbLost || (engNack && !contNack));
  assign finish   = inXfer && !abort && engByteDone && lastDone;

  always_comb begin
    stb.capSize   = (state == ST_SIZE) && accept;
    stb.capHdr    = (state == ST_HDRI) && accept;
    stb.loadWord  = inXfer && accept;
    stb.dropWord  = (state == ST_DRAIN) && accept;
    stb.popByte   = txValid && txReady;
    stb.countDone = inXfer && !abort && engByteDone;
    stb.flush     = abort;
  end

  always_comb begin
    stateNext = state;
    badNext   = badQ;
    case (state)
      ST_HDR0: if (accept) begin
        stateNext = ST_SIZE;
        badNext   = !protoOk;
      end
      ST_SIZE: if (accept) stateNext = ST_HDRI;
      ST_HDRI: if (accept) stateNext = badQ ? ST_DRAIN : ST_CMD;
      ST_CMD:  if (cmdReady) stateNext = ST_XFER;
      ST_XFER: begin
        if (abort)       stateNext = ST_DRAIN;
        else if (finish) stateNext = ST_HDR0;
      end
      ST_DRAIN: if (!loadsLeft) stateNext = ST_HDR0;
      default: stateNext = ST_HDR0;
    endcase
  end

  always_comb begin
    irqNext           = '0;
    irqNext[IRQ_DONE] = finish;
    irqNext[IRQ_NACK] = inXfer && engNack;
    irqNext[IRQ_ARB]  = inXfer && engArbLost;
    irqNext[IRQ_FMT]  = (state == ST_HDR0) && accept && !protoOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_HDR0;
      badQ     <= 1'b0;
      irqPulse <= '0;
    end else begin
      state    <= stateNext;
      badQ     <= badNext;
      irqPulse <= irqNext;
    end
  end

  // R3: a presented command stays up until the engine takes it
  assert_cmd_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> cmdValid);
  // R2: the complete flag never lasts more than one cycle
  assert_complete_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse[IRQ_DONE] |=> !irqPulse[IRQ_DONE]);
  // R7: an aborting NACK is never followed by a complete flag
  assert_abort_no_complete_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inXfer && engNack && !contNack) |=> !irqPulse[IRQ_DONE]);
  // R8: lost arbitration always leaves the transfer
  assert_arb_leaves_xfer_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inXfer && engArbLost) |=> !txValid && (state != ST_XFER));

endmodule

// File: rtl/pkt_i2c_decoder.sv
module pkt_i2c_decoder
  import pkt_dec_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [31:0]      inWord,
  input  logic             inValid,
  output logic             inReady,
  output logic             cmdValid,
  input  logic             cmdReady,
  output logic [9:0]       cmdAddr,
  output logic             cmdRead,
  output logic             cmdTenBit,
  output logic [1:0]       cmdEnd,
  output logic [LEN_W-1:0] cmdLenM1,
  output logic [7:0]       txByte,
  output logic             txValid,
  input  logic             txReady,
  input  logic             engByteDone,
  input  logic             engNack,
  input  logic             engArbLost,
  output logic [7:0]       irqPulse
);

  strobe_t stb;
  logic contNack, bufEmpty, loadsLeft, lastDone;

  pkt_dec_ctl ctl_i (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .protoOk(inWord[PROTO_BIT]), .inReady(inReady),
    .cmdValid(cmdValid), .cmdReady(cmdReady),
    .txValid(txValid), .txReady(txReady),
    .engByteDone(engByteDone), .engNack(engNack), .engArbLost(engArbLost),
    .isRead(cmdRead), .contNack(contNack),
    .bufEmpty(bufEmpty), .loadsLeft(loadsLeft), .lastDone(lastDone),
    .stb(stb), .irqPulse(irqPulse)
  );

  pkt_dec_datapath #(.LEN_W(LEN_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .inWord(inWord),
    .cmdAddr(cmdAddr), .cmdRead(cmdRead), .cmdTenBit(cmdTenBit),
    .cmdEnd(cmdEnd), .cmdLenM1(cmdLenM1), .contNack(contNack),
    .txByte(txByte), .bufEmpty(bufEmpty), .loadsLeft(loadsLeft),
    .lastDone(lastDone)
  );

endmodule

// File: tb/pkt_i2c_decoder_tb.sv
module pkt_i2c_decoder_tb_top;

  localparam int LEN_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] inWord = '0;
  logic inValid = 1'b0, cmdReady = 1'b1, txReady = 1'b1;
  logic engByteDone = 1'b0, engNack = 1'b0, engArbLost = 1'b0;
  logic inReady, cmdValid, cmdRead, cmdTenBit, txValid;
  logic [9:0] cmdAddr;
  logic [1:0] cmdEnd;
  logic [LEN_W-1:0] cmdLenM1;
  logic [7:0] txByte, irqPulse;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pkt_i2c_decoder #(.LEN_W(LEN_W)) dut_i (.*);

  typedef struct packed {
    logic [31:0] h0, sz, hi, p0, p1;
    logic [2:0]  nPay;
    logic [3:0]  abortAt;
    logic        useArb;
    logic [9:0]  eAddr;
    logic        eRead;
    logic [1:0]  eEnd;
    logic        eCmd, eComp, eNack, eArb, eErr;
  } vec_t;

  localparam logic [31:0] GOOD = 32'h0001_1010;
  localparam logic [31:0] BAD  = 32'h0001_1000;

  localparam vec_t VECS [0:9] = '{
    '{GOOD, 32'd4, 32'h0002_00A0, 32'h4433_2211, 32'h0000_0055, 3'd2, 4'hF, 1'b0, 10'h0A0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{GOOD, 32'd2, 32'h0009_00A0, 32'h0, 32'h0, 3'd0, 4'hF, 1'b0, 10'h0A1, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{GOOD, 32'd0, 32'h0000_803D, 32'h0000_00AB, 32'h0, 3'd1, 4'hF, 1'b0, 10'h03C, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{GOOD, 32'd1, 32'h0001_8010, 32'h0000_BEEF, 32'h0, 3'd1, 4'hF, 1'b0, 10'h010, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{GOOD, 32'd3, 32'h0004_02F5, 32'hDDCC_BBAA, 32'h0, 3'd1, 4'hF, 1'b0, 10'h2F5, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{GOOD, 32'd7, 32'h0002_00A0, 32'h8765_4321, 32'hEFCD_AB09, 3'd2, 4'd2, 1'b0, 10'h0A0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{GOOD, 32'd3, 32'h0022_00A0, 32'h0403_0201, 32'h0, 3'd1, 4'd1, 1'b0, 10'h0A0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{BAD,  32'd4, 32'h0002_00A0, 32'h1111_1111, 32'h2222_2222, 3'd2, 4'hF, 1'b0, 10'h000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{BAD,  32'd5, 32'h0008_00A0, 32'h0, 32'h0, 3'd0, 4'hF, 1'b0, 10'h000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{GOOD, 32'd3, 32'h0008_00A0, 32'h0, 32'h0, 3'd0, 4'd1, 1'b1, 10'h0A1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runVec(input int v);
    vec_t t = VECS[v];
    logic [31:0] words [0:4];
    int nW = 3 + int'(t.nPay);
    int len = int'(t.sz[LEN_W-1:0]) + 1;
    bit isRd = t.hi[19];
    bit cn = t.hi[21];
    int wi = 0, txIdx = 0, doneIdx = 0, pendIdx = 0, cyc = 0, extra = 0;
    int nComp = 0, nNack = 0, nArb = 0, nErr = 0, nCmd = 0;
    bit pend = 0, aborted = 0, rdActive = 0, toggle = 0, fin = 0;
    words[0] = t.h0; words[1] = t.sz; words[2] = t.hi; words[3] = t.p0; words[4] = t.p1;
    while (extra < 4 && cyc < 400) begin
      int rep;
      @(negedge clk);
      cyc++;
      if (irqPulse[7]) nComp++;
      if (irqPulse[3]) nNack++;
      if (irqPulse[2]) nArb++;
      if (irqPulse[1]) nErr++;
      engByteDone = 1'b0; engNack = 1'b0; engArbLost = 1'b0;
      rep = -1;
      if (pend) begin rep = pendIdx; pend = 0; end
      else if (rdActive && toggle && doneIdx < len) rep = doneIdx;
      toggle = !toggle;
      if (rep >= 0 && !aborted) begin
        if (rep == int'(t.abortAt)) begin
          if (t.useArb) begin engArbLost = 1'b1; aborted = 1; end
          else begin engNack = 1'b1; engByteDone = cn; aborted = !cn; end
        end else engByteDone = 1'b1;
        doneIdx++;
      end
      if (cmdValid) begin
        nCmd++;
        check(cmdAddr == t.eAddr, $sformatf("R3 addr v%0d", v), 32'(cmdAddr), 32'(t.eAddr));
        check(cmdRead == t.eRead, $sformatf("R3 read v%0d", v), 32'(cmdRead), 32'(t.eRead));
        check(cmdTenBit == t.hi[18], $sformatf("R3 tenbit v%0d", v), 32'(cmdTenBit), 32'(t.hi[18]));
        check(cmdEnd == t.eEnd, $sformatf("R4 end v%0d", v), 32'(cmdEnd), 32'(t.eEnd));
        check(cmdLenM1 == t.sz[LEN_W-1:0], $sformatf("R2 len v%0d", v), 32'(cmdLenM1), t.sz);
        if (isRd) rdActive = 1;
      end
      if (txValid) begin
        logic [31:0] w = (txIdx < 4) ? t.p0 : t.p1;
        logic [7:0] eb = w[8*(txIdx%4) +: 8];
        check(txByte == eb && txIdx < len, $sformatf("R5 byte%0d v%0d", txIdx, v), 32'(txByte), 32'(eb));
        pend = 1; pendIdx = txIdx; txIdx++;
      end
      if (wi < nW) begin
        inValid = 1'b1; inWord = words[wi];
        if (inReady) wi++;
      end else inValid = 1'b0;
      if (fin) extra++;
      else if (wi == nW && (nComp > 0 || nArb > 0 || (nNack > 0 && !cn) || nErr > 0)) fin = 1;
    end
    inValid = 1'b0; engByteDone = 1'b0; engNack = 1'b0; engArbLost = 1'b0;
    check(cyc < 400, $sformatf("R2 finished v%0d", v), 32'(cyc), 32'd400);
    check(nCmd == int'(t.eCmd), $sformatf("R1 commands v%0d", v), 32'(nCmd), 32'(t.eCmd));
    check(nComp == int'(t.eComp), $sformatf("R2 complete v%0d", v), 32'(nComp), 32'(t.eComp));
    check(nNack == int'(t.eNack), $sformatf("R7 nack v%0d", v), 32'(nNack), 32'(t.eNack));
    check(nArb == int'(t.eArb), $sformatf("R8 arb v%0d", v), 32'(nArb), 32'(t.eArb));
    check(nErr == int'(t.eErr), $sformatf("R1 malformed v%0d", v), 32'(nErr), 32'(t.eErr));
    check(wi == nW, $sformatf("%s words v%0d", t.eErr ? "R1" : (t.eComp ? "R6" : "R7"), v), 32'(wi), 32'(nW));
    if (t.eComp && !isRd)
      check(txIdx == len, $sformatf("R5 byte count v%0d", v), 32'(txIdx), 32'(len));
    check(inReady && !cmdValid && !txValid, $sformatf("R2 idle after v%0d", v),
          {29'd0, inReady, cmdValid, txValid}, 32'h4);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: state held during and after reset
    check(inReady && !cmdValid && !txValid && irqPulse == 8'h00, "R10 reset",
          {20'd0, irqPulse, 1'b0, inReady, cmdValid, txValid}, 32'h4);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady && !cmdValid && !txValid && irqPulse == 8'h00, "R10 after reset",
          {20'd0, irqPulse, 1'b0, inReady, cmdValid, txValid}, 32'h4);

    for (int v = 0; v < 10; v++) runVec(v);

    // R9: stray engine reports while idle
    @(negedge clk);
    engByteDone = 1'b1; engNack = 1'b1; engArbLost = 1'b1;
    @(negedge clk);
    engByteDone = 1'b0; engNack = 1'b0; engArbLost = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(irqPulse == 8'h00, "R9 idle report flags", 32'(irqPulse), 32'h0);
    end
    // R9: the next packet still counts its own bytes
    runVec(0);
    runVec(1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule